// File: doc/BRIEF.md
# Scaler Coefficient Memory Load Sequencer

The sequencer fills the coefficient memory of a polyphase scaler. The memory sits behind two registers: an index register that can step forward by itself, and a data register. After a start pulse, the block writes the index register once, with start address 0 and the step-forward flag set. It then sends the data words. Each word carries two 16-bit coefficients. The seven tap coefficients come in on a flat input bus. One seven-tap set serves every phase, so the coefficient at flat position i is always tap (i mod 7). The full table is 17 phases of 7 taps, which is 119 positions, sent as 60 words. A word may join the last tap of one phase to the first tap of the next. The upper half of the final word is position 119, which is tap 0.

Only one scaler may be loaded: the one whose id is 1. The select input is sampled with the start pulse. Any other id makes the block refuse the load: it issues no write and raises an error flag. A separate model of the target memory goes with the block. It holds the index register with its step-forward behaviour and a readback port, so a bench can check the stored table.

Writes leave the block on a valid/ready register port. A write is offered by raising `wr_valid` together with the address select and the data. It completes on a clock edge where `wr_ready` is high. While `wr_ready` is low, the block holds the write unchanged, so the target can stall it for any number of cycles.

Top module: `scl_coef_loader`

## Requirements
- R1: After reset, `busy`, `err` and `wr_valid` are 0.
- R2: The first write of a load targets the index register (`wr_addr` = 0). Its data is 32'h0000_0400: the step-forward flag is bit 10 and the start index 0 is in bits 5:0.
- R3: After the index write, exactly 60 data writes follow (`wr_addr` = 1). Word k carries tap ((2k) mod 7) in bits 15:0 and tap ((2k+1) mod 7) in bits 31:16. Tap t is `coef_flat[16t+15:16t]`.
- R4: Word 59 carries tap 6 in its lower half and tap 0 in its upper half.
- R5: While `wr_valid` is 1 and `wr_ready` is 0, the next cycle keeps `wr_valid` at 1 with `wr_addr` and `wr_data` unchanged.
- R6: `busy` rises in the cycle after an accepted start. It falls in the cycle after the handshake of the last data write.
- R7: A start with `scaler_sel` other than 1 causes no write and sets `err` from the next cycle. `err` stays set until a start with `scaler_sel` = 1, and `busy` stays 0.
- R8: Changes on `scaler_sel` during a load do not alter the load: there is no error and the full table is still written.
- R9: A start pulse while `busy` is 1 is ignored, so a load makes exactly 61 writes.
- R10: The memory model loads its index from bits 5:0 of an index write and its step flag from bit 10. On each data write it stores the word at the index and, with the flag set, advances the index by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a load |
| scaler_sel | input | 2 | Scaler id, sampled with start |
| coef_flat | input | 112 | Seven 16-bit tap coefficients, tap t at bits 16t+15:16t |
| busy | output | 1 | Load in progress |
| err | output | 1 | Last start named a scaler that may not load |
| wr_valid | output | 1 | Register write offered |
| wr_ready | input | 1 | Target accepts the write this cycle |
| wr_addr | output | 1 | 0 = index register, 1 = data register |
| wr_data | output | 32 | Write data |

## Verification
The hardest case to reach from the ports is a word that crosses a phase boundary while the target is stalling. The pairing of taps has to survive a held write, and the tap counters must not advance without a handshake. The stimulus runs loads with a pseudo-random ready pattern, so stalls land on many of the 60 words. In the middle of a load it also changes the select input and pulses start again. Afterwards the bench reads back every stored word and the final index from the memory model.

// File: rtl/scl_pkg.sv
package scl_pkg;
  localparam int NTAPS   = 7;
  localparam int NPHASE  = 17;
  localparam int CW      = 16;
  localparam int DW      = 32;
  localparam int IDX_W   = 6;
  localparam int AI_BIT  = 10;
  localparam int SEL_W   = 2;
  localparam int LOAD_ID = 1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_IDX  = 2'd1,
    ST_DATA = 2'd2
  } ld_state_t;
endpackage

// File: rtl/scl_tap_walk.sv
module scl_tap_walk #(
  parameter int NTAPS = scl_pkg::NTAPS,
  localparam int TW   = $clog2(NTAPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          step,
  output logic [TW-1:0] tap_lo,
  output logic [TW-1:0] tap_hi
);
  localparam logic [TW-1:0] LAST2 = TW'(NTAPS - 2);

  function automatic logic [TW-1:0] adv2(input logic [TW-1:0] t);
    return (t >= LAST2) ? t - LAST2 : t + TW'(2);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      tap_lo <= '0;
      tap_hi <= TW'(1);
    end else if (step) begin
      tap_lo <= adv2(tap_lo);
      tap_hi <= adv2(tap_hi);
    end
  end

  AST_TAP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_lo < TW'(NTAPS)) && (tap_hi < TW'(NTAPS))); // R3
  AST_TAP_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    tap_hi == ((tap_lo == TW'(NTAPS - 1)) ? '0 : tap_lo + TW'(1))); // R3
endmodule

// File: rtl/scl_pair_mux.sv
module scl_pair_mux #(
  parameter int NTAPS = scl_pkg::NTAPS,
  parameter int CW    = scl_pkg::CW,
  localparam int TW   = $clog2(NTAPS)
) (
  input  logic [NTAPS*CW-1:0] coef_flat,
  input  logic [TW-1:0]       tap_lo,
  input  logic [TW-1:0]       tap_hi,
  output logic [2*CW-1:0]     pair
);
  logic [CW-1:0] taps [NTAPS];

  for (genvar g = 0; g < NTAPS; g++) begin : g_unpack
    assign taps[g] = coef_flat[g*CW +: CW];
  end

  always_comb begin
    pair = {taps[tap_hi], taps[tap_lo]};
  end
endmodule

// File: rtl/scl_coef_mem.sv
module scl_coef_mem #(
  parameter int DW     = scl_pkg::DW,
  parameter int IDX_W  = scl_pkg::IDX_W,
  parameter int AI_BIT = scl_pkg::AI_BIT,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic             wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [DW-1:0]    rd_data,
  output logic [IDX_W-1:0] cur_idx
);
  logic [DW-1:0] mem [DEPTH];
  logic          auto_inc;
  logic          hs;

  assign wr_ready = !stall;
  assign hs       = wr_valid && wr_ready;
  assign rd_data  = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_idx  <= '0;
      auto_inc <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (hs) begin
      if (!wr_addr) begin
        cur_idx  <= wr_data[IDX_W-1:0];
        auto_inc <= wr_data[AI_BIT];
      end else begin
        mem[cur_idx] <= wr_data;
        if (auto_inc) cur_idx <= cur_idx + 1'b1;
      end
    end
  end

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && wr_addr && auto_inc) |=> cur_idx == $past(cur_idx) + 1'b1); // R10
endmodule

// File: rtl/scl_coef_loader.sv
module scl_coef_loader
  import scl_pkg::*;
#(
  parameter int N_TAPS   = NTAPS,
  parameter int N_PHASE  = NPHASE,
  parameter int COEF_W   = CW,
  parameter int DATA_W   = DW,
  parameter int AI_POS   = AI_BIT,
  parameter int SEL_BITS = SEL_W,
  parameter int ALLOW_ID = LOAD_ID
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [SEL_BITS-1:0]      scaler_sel,
  input  logic [N_TAPS*COEF_W-1:0] coef_flat,
  output logic                     busy,
  output logic                     err,
  output logic                     wr_valid,
  input  logic                     wr_ready,
  output logic                     wr_addr,
  output logic [DATA_W-1:0]        wr_data
);
  localparam int NCOEF = N_TAPS * N_PHASE;
  localparam int NWORD = (NCOEF + 1) / 2;
  localparam int WCW   = $clog2(NWORD);
  localparam int TW    = $clog2(N_TAPS);
  localparam logic [DATA_W-1:0] IDX_WORD = DATA_W'(1) << AI_POS;

  ld_state_t         state;
  logic [WCW-1:0]    wcnt;
  logic [TW-1:0]     tap_lo, tap_hi;
  logic [2*COEF_W-1:0] pair;
  logic              hs, go;

  assign hs = wr_valid && wr_ready;
  assign go = (state == ST_IDLE) && start && (scaler_sel == SEL_BITS'(ALLOW_ID));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      wcnt  <= '0;
      err   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          if (go) begin
            state <= ST_IDX;
            err   <= 1'b0;
          end else begin
            err <= 1'b1;
          end
        end
        ST_IDX: if (hs) begin
          state <= ST_DATA;
          wcnt  <= '0;
        end
        ST_DATA: if (hs) begin
          if (wcnt == WCW'(NWORD - 1)) state <= ST_IDLE;
          else                         wcnt  <= wcnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  scl_tap_walk #(.NTAPS(N_TAPS)) u_walk (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (go),
    .step   (hs && (state == ST_DATA)),
    .tap_lo (tap_lo),
    .tap_hi (tap_hi)
  );

  scl_pair_mux #(.NTAPS(N_TAPS), .CW(COEF_W)) u_mux (
    .coef_flat (coef_flat),
    .tap_lo    (tap_lo),
    .tap_hi    (tap_hi),
    .pair      (pair)
  );

  always_comb begin
    busy     = (state != ST_IDLE);
    wr_valid = busy;
    wr_addr  = (state == ST_DATA);
    wr_data  = (state == ST_DATA) ? DATA_W'(pair) : IDX_WORD;
  end

  AST_FIRST_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !wr_addr); // R2
  AST_HOLD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> wr_valid && $stable(wr_addr) && $stable(wr_data)); // R5
  AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(wr_addr && hs)); // R6
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !wr_valid); // R7
  AST_FINAL_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_addr && wcnt == WCW'(NWORD - 1)) |-> (tap_hi == '0)); // R4
endmodule

// File: tb/tb_scl_coef_loader.sv
`timescale 1ns/1ps
module tb_scl_coef_loader;
  localparam int NT = 7;
  localparam int NW = 60;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    scaler_sel = 2'd0;
  logic [NT*16-1:0] coef_flat = '0;
  logic          busy, err, wr_valid, wr_ready, wr_addr;
  logic [31:0]   wr_data;
  logic          stall = 1'b0;
  logic          stall_en = 1'b0;
  logic [5:0]    rd_idx = '0;
  logic [31:0]   rd_data;
  logic [5:0]    cur_idx;

  int checks = 0;
  int errors = 0;
  int nwr = 0;
  int nidx = 0;
  int hold_bad = 0;
  logic [31:0] first_data;
  logic        first_addr;
  logic [15:0] lfsr = 16'hACE1;
  logic [31:0] shadow [64];

  always #2.5 clk = ~clk;

  scl_coef_loader dut (
    .clk(clk), .rst_n(rst_n), .start(start), .scaler_sel(scaler_sel),
    .coef_flat(coef_flat), .busy(busy), .err(err), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  scl_coef_mem u_mem (
    .clk(clk), .rst_n(rst_n), .stall(stall), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .cur_idx(cur_idx)
  );

  // ready pattern
  always @(negedge clk) begin
    lfsr  <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    stall <= stall_en & lfsr[0];
  end

  // write monitor and hold check (R5)
  logic        pv = 1'b0, pr = 1'b0, pa = 1'b0;
  logic [31:0] pd = '0;
  always @(posedge clk) begin
    if (rst_n) begin
      if (pv && !pr && (!wr_valid || wr_data != pd || wr_addr != pa)) hold_bad++;
      if (wr_valid && wr_ready) begin
        if (nwr == 0) begin first_addr = wr_addr; first_data = wr_data; end
        nwr++;
        if (!wr_addr) nidx++;
      end
    end
    pv = wr_valid; pr = wr_ready; pd = wr_data; pa = wr_addr;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] cf(input logic [7:0] seed, input int t);
    return {seed ^ 8'(t * 17), 8'(t * 29 + 3)};
  endfunction

  // row: {sel[1:0], stall_en, seed[7:0], exp_err}
  localparam logic [11:0] VEC [5] = '{
    {2'd1, 1'b0, 8'h3C, 1'b0},
    {2'd1, 1'b1, 8'hA5, 1'b0},
    {2'd0, 1'b0, 8'h11, 1'b1},
    {2'd3, 1'b1, 8'h22, 1'b1},
    {2'd1, 1'b1, 8'h5A, 1'b0}
  };

  initial begin : wd
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !err && !wr_valid, "R1 reset outputs", {busy, err, wr_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int r = 0; r < 5; r++) begin
      logic [1:0] sel;
      logic       se, xe;
      logic [7:0] seed;
      int         wait_n;
      {sel, se, seed, xe} = VEC[r];
      for (int t = 0; t < NT; t++) coef_flat[t*16 +: 16] = cf(seed, t);
      stall_en = se;
      nwr = 0; nidx = 0; hold_bad = 0;
      scaler_sel = sel;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (xe) begin
        chk(err && !busy, "R7 err set, busy low", {busy, err}, 2'b01);
        scaler_sel = 2'd1;
        repeat (10) @(negedge clk);
        chk(nwr == 0, "R7 no writes on refused id", nwr, 0);
        chk(err, "R7 err held", err, 1);
        for (int k = 0; k < NW; k++) begin
          rd_idx = 6'(k);
          #0.1;
          chk(rd_data == shadow[k], "R7 memory untouched", rd_data, shadow[k]);
        end
        scaler_sel = sel;
      end else begin
        chk(busy && !err, "R6 busy after start", {busy, err}, 2'b10);
        wait_n = 0;
        while (busy && wait_n < 5000) begin
          if (wait_n == 20) begin
            scaler_sel = 2'd2;  // R8
            start = 1'b1;       // R9
          end else begin
            start = 1'b0;
          end
          @(negedge clk);
          wait_n++;
        end
        start = 1'b0;
        scaler_sel = sel;
        chk(!busy, "R6 busy dropped", busy, 0);
        chk(!err, "R8 no error after select change", err, 0);
        chk(nwr == NW + 1, "R9 write count", nwr, NW + 1);
        chk(nidx == 1, "R9 single index write", nidx, 1);
        chk(first_addr == 1'b0 && first_data == 32'h0000_0400, "R2 index write",
            {first_addr, first_data[30:0]}, 32'h0000_0400);
        chk(hold_bad == 0, "R5 held write changed", hold_bad, 0);
        chk(cur_idx == 6'(NW), "R10 final index", cur_idx, NW);
        for (int k = 0; k < NW; k++) begin
          logic [31:0] e;
          e = {cf(seed, (2*k+1) % NT), cf(seed, (2*k) % NT)};
          shadow[k] = e;
          rd_idx = 6'(k);
          #0.1;
          chk(rd_data == e, (k == NW-1) ? "R4 final word" : "R3 data word", rd_data, e);
        end
        chk(shadow[NW-1][31:16] == cf(seed, 0), "R4 upper half is tap 0",
            shadow[NW-1][31:16], cf(seed, 0));
      end
      @(negedge clk);
    end

    // R1 again: reset in mid load
    scaler_sel = 2'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!busy && !err && !wr_valid, "R1 reset during load", {busy, err, wr_valid}, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule